// File: doc/BRIEF.md
# Four-Channel Event Timer with Timestamp Counter

This block is a register-mapped timer unit. Four independent event channels count down a programmed 16-bit value. Each channel counts in ticks of a timebase it selects itself, and it emits a one-cycle interrupt pulse each time it expires. Each channel runs either periodically, reloading its programmed value after every expiry, or as a one-shot, stopping after one expiry. A fifth counter is a 32-bit timestamp that counts up from reset. It advances on the raw system clock or on any of the prescaled ticks, and software can read it at any time.

A shared prescaler turns the system clock into single-cycle strobes at 1 us, 10 us, 100 us and 1 ms. The parameter `CYCLES_PER_US` sets the number of system clocks in one microsecond. Each slower strobe is derived from the next faster one by a divide-by-ten stage. Software talks to the unit over a simple bus. A write takes effect on the clock edge where `bus_sel` and `bus_wr` are both high. Read data is a combinational view of the register addressed by `bus_addr`.

Each event channel is a three-state machine. In `CH_HALT` the count is frozen. In `CH_RUN` the count decrements on each selected tick. In `CH_DONE` a one-shot channel has expired and waits. The transitions are:
- HALT->RUN when the channel's enable bit is 1.
- RUN->HALT when the enable bit is 0.
- RUN->DONE on a one-shot expiry.
- DONE->HALT on any write to the control register. This transition also reloads the count.

Top module: `multi_timer_unit`

## Requirements
- R1: After reset, the control register, the four channel counts and all interrupt outputs are zero. The timestamp starts from zero.
- R2: The register map uses word index `bus_addr[4:2]`: 0 is control, 1 to 4 are the counts of channels 0 to 3, and 5 is the timestamp. Only control bits 19:12 and 10:0 are implemented, and all other control bits read 0. A channel count reads back zero-extended.
- R3: The 1 us tick repeats every `CYCLES_PER_US` clocks. The 10 us, 100 us and 1 ms ticks each repeat every ten of the next faster tick.
- R4: Channel i takes its timebase from control bits [2i+1:2i]. Code 0 selects 1 us, code 1 selects 10 us, code 2 selects 100 us and code 3 selects 1 ms.
- R5: Control bit 16+i enables channel i. The state machine enters RUN one clock after the bit is set. While the bit is 0 the count is frozen and no interrupt is raised.
- R6: When control bit 12+i is 1, channel i is periodic. A programmed value N gives an interrupt every N+1 selected ticks, and N is reloaded after each expiry.
- R7: When control bit 12+i is 0, channel i is a one-shot. It pulses once when it ticks at zero, then holds its count at 0 with no further pulses. Only a control write moves it back to HALT and reloads N.
- R8: `irq[i]` belongs to channel i. It is high for exactly one clock, in the cycle after the expiring tick.
- R9: Timestamp select code at control bits [10:8]: 0 counts every clock, 1 to 4 count the 1 us, 10 us, 100 us and 1 ms ticks, and 5 to 7 stop the counter. The counter wraps modulo 2^32.
- R10: Bus writes to the timestamp address have no effect.
- R11: Writing a channel's count address loads both the reload value and the live count, and this write takes priority over counting that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| irq | output | 4 | One-cycle expiry pulse per channel |

## Verification
The bench keeps a cycle-level model of every counter and compares the interrupt vector on every clock and every read against it. The bench also aims at specific corner cases, and each is paired below with the failure it would expose:
- Interval length: the spacing between periodic pulses is measured. An off-by-one reload shows up as an interval of N or N+2 ticks instead of N+1.
- Timebase codes: the slow timebase codes are run long enough to see two pulses. A swapped code shows up as a wrong interval.
- One-shot hold: the one-shot is left idle well past its expiry and must stay silent. A design that forgets to stop would pulse again.
- Disable mid-count: a channel is disabled mid-count and must keep its count. A design that resets or keeps counting would change the readback.
- Timestamp writes: writes to the timestamp are tried, and a design that accepts them would jump the count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int unsigned NUM_CH        = 4;
    localparam int unsigned NUM_RATES     = 4;
    localparam int unsigned DECADE        = 10;
    localparam int unsigned CNT_W         = 16;
    localparam int unsigned STAMP_W       = 32;
    localparam int unsigned BUS_W         = 32;
    localparam int unsigned ADDR_W        = 5;
    localparam int unsigned IDX_W         = ADDR_W - 2;
    localparam int unsigned RATE_W        = $clog2(NUM_RATES);
    localparam int unsigned EN_LSB        = 16;
    localparam int unsigned MODE_LSB      = 12;
    localparam int unsigned STAMP_SEL_LSB = 8;
    localparam int unsigned STAMP_SEL_W   = 3;
    localparam int unsigned STAMP_IDX     = NUM_CH + 1;
    localparam logic [BUS_W-1:0] CTRL_MASK = 32'h000F_F7FF;

    typedef enum logic [1:0] {
        CH_HALT = 2'd0,
        CH_RUN  = 2'd1,
        CH_DONE = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic              enable;
        logic              periodic;
        logic [RATE_W-1:0] rate;
    } ch_cfg_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int unsigned CYCLES_PER_US = 125
) (
    input  logic                          clk,
    input  logic                          rst_n,
    output logic [tmr_pkg::NUM_RATES-1:0] tick
);
    import tmr_pkg::*;

    localparam int unsigned BASE_W = (CYCLES_PER_US > 1) ? $clog2(CYCLES_PER_US) : 1;
    localparam int unsigned DEC_W  = $clog2(DECADE);

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_stage
        logic strobe_q;
        assign tick[g] = strobe_q;

        if (g == 0) begin : g_base
            logic [BASE_W-1:0] base_cnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    base_cnt <= '0;
                    strobe_q <= 1'b0;
                end else begin
                    strobe_q <= (base_cnt == BASE_W'(CYCLES_PER_US - 1));
                    base_cnt <= (base_cnt == BASE_W'(CYCLES_PER_US - 1)) ? '0 : base_cnt + 1'b1;
                end
            end
            if (CYCLES_PER_US > 1) begin : g_gap
                // R3: the base strobe never lasts two clocks
                p_base_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
                    tick[0] |=> !tick[0]);
            end
        end else begin : g_decade
            logic [DEC_W-1:0] dec_cnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    dec_cnt  <= '0;
                    strobe_q <= 1'b0;
                end else begin
                    strobe_q <= tick[g-1] && (dec_cnt == DEC_W'(DECADE - 1));
                    if (tick[g-1]) begin
                        dec_cnt <= (dec_cnt == DEC_W'(DECADE - 1)) ? '0 : dec_cnt + 1'b1;
                    end
                end
            end
            p_decade_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
                tick[g] |-> $past(tick[g-1]));
        end
    end
endmodule

// File: rtl/tmr_event_chan.sv
module tmr_event_chan (
    input  logic                            clk,
    input  logic                            rst_n,
    input  tmr_pkg::ch_cfg_t                cfg,
    input  logic [tmr_pkg::NUM_RATES-1:0]   tick,
    input  logic                            ctrl_wr,
    input  logic                            cnt_wr,
    input  logic [tmr_pkg::CNT_W-1:0]       cnt_wdata,
    output logic [tmr_pkg::CNT_W-1:0]       count,
    output logic                            irq
);
    import tmr_pkg::*;

    ch_state_e        state_q, state_nx;
    logic [CNT_W-1:0] count_q, count_nx, reload_q;
    logic             fire;
    logic             tick_sel;

    assign tick_sel = tick[cfg.rate];

    always_comb begin
        state_nx = state_q;
        count_nx = count_q;
        fire     = 1'b0;
        unique case (state_q)
            CH_HALT: begin
                if (cfg.enable) state_nx = CH_RUN;
            end
            CH_RUN: begin
                if (!cfg.enable) begin
                    state_nx = CH_HALT;
                end else if (tick_sel) begin
                    if (count_q == '0) begin
                        fire = 1'b1;
                        if (cfg.periodic) count_nx = reload_q;
                        else              state_nx = CH_DONE;
                    end else begin
                        count_nx = count_q - 1'b1;
                    end
                end
            end
            CH_DONE: begin
                if (ctrl_wr) begin
                    state_nx = CH_HALT;
                    count_nx = reload_q;
                end
            end
            default: state_nx = CH_HALT;
        endcase
        if (cnt_wr) count_nx = cnt_wdata;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_HALT;
        else        state_q <= state_nx;
    end

    // outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= '0;
            reload_q <= '0;
            irq      <= 1'b0;
        end else begin
            count_q <= count_nx;
            irq     <= fire;
            if (cnt_wr) reload_q <= cnt_wdata;
        end
    end

    assign count = count_q;

    p_halt_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HALT && !cnt_wr) |=> ($stable(count_q) && !irq));
    p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.enable |=> !irq);
    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_DONE && !ctrl_wr && !cnt_wr) |=> ($stable(count_q) && !irq));
    p_fire_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(count_q) == '0));
endmodule

// File: rtl/tmr_stamp_ctr.sv
module tmr_stamp_ctr (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [tmr_pkg::STAMP_SEL_W-1:0]    sel,
    input  logic [tmr_pkg::NUM_RATES-1:0]      tick,
    output logic [tmr_pkg::STAMP_W-1:0]        stamp
);
    import tmr_pkg::*;

    logic advance;

    always_comb begin
        advance = 1'b0;
        if (sel == '0) begin
            advance = 1'b1;
        end else if (int'(sel) <= NUM_RATES) begin
            for (int r = 0; r < NUM_RATES; r++) begin
                if (int'(sel) == r + 1) advance = tick[r];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       stamp <= '0;
        else if (advance) stamp <= stamp + 1'b1;
    end

    p_stamp_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) |=> (stamp == $past(stamp) + 1'b1));
    p_stamp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sel) > NUM_RATES) |=> $stable(stamp));
endmodule

// File: rtl/multi_timer_unit.sv
module multi_timer_unit #(
    parameter int unsigned CYCLES_PER_US = 125
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic [3:0]  irq
);
    import tmr_pkg::*;

    logic [BUS_W-1:0]     ctrl_q;
    logic [IDX_W-1:0]     word_idx;
    logic                 wr_en;
    logic                 ctrl_wr;
    logic [NUM_RATES-1:0] tick;
    logic [STAMP_W-1:0]   stamp;
    logic [CNT_W-1:0]     ch_count [NUM_CH];

    assign word_idx = bus_addr[ADDR_W-1:2];
    assign wr_en    = bus_sel && bus_wr;
    assign ctrl_wr  = wr_en && (word_idx == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= bus_wdata & CTRL_MASK;
    end

    tmr_prescaler #(.CYCLES_PER_US(CYCLES_PER_US)) u_prescaler (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        ch_cfg_t cfg;
        logic    cnt_wr;
        assign cfg.enable   = ctrl_q[EN_LSB + c];
        assign cfg.periodic = ctrl_q[MODE_LSB + c];
        assign cfg.rate     = ctrl_q[RATE_W*c +: RATE_W];
        assign cnt_wr       = wr_en && (word_idx == IDX_W'(c + 1));

        tmr_event_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg       (cfg),
            .tick      (tick),
            .ctrl_wr   (ctrl_wr),
            .cnt_wr    (cnt_wr),
            .cnt_wdata (bus_wdata[CNT_W-1:0]),
            .count     (ch_count[c]),
            .irq       (irq[c])
        );
    end

    tmr_stamp_ctr u_stamp (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (ctrl_q[STAMP_SEL_LSB +: STAMP_SEL_W]),
        .tick  (tick),
        .stamp (stamp)
    );

    always_comb begin
        bus_rdata = '0;
        if (word_idx == '0) begin
            bus_rdata = ctrl_q;
        end else if (word_idx == IDX_W'(STAMP_IDX)) begin
            bus_rdata = BUS_W'(stamp);
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (word_idx == IDX_W'(i + 1)) bus_rdata = BUS_W'(ch_count[i]);
            end
        end
    end

    p_ctrl_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> ((ctrl_q & ~CTRL_MASK) == '0));
endmodule

// File: tb/test_multi_timer_unit.sv
module test_multi_timer_unit;
    localparam int CPU = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    multi_timer_unit #(.CYCLES_PER_US(CPU)) i_multi_timer_unit (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // behavioural reference model
    int        m_pre;
    int        m_dec [4];
    bit [3:0]  m_tick;
    bit [31:0] m_ctrl;
    bit [31:0] m_stamp;
    int        m_cnt [4];
    int        m_rel [4];
    int        m_st  [4];
    bit [3:0]  m_irq;

    always @(posedge clk or negedge rst_n) begin
        bit [3:0] nt;
        bit wctl;
        int ssel;
        int rsel;
        bit en;
        bit per;
        if (!rst_n) begin
            m_pre = 0; m_tick = 0; m_ctrl = 0; m_stamp = 0; m_irq = 0;
            for (int k = 0; k < 4; k++) begin
                m_dec[k] = 0; m_cnt[k] = 0; m_rel[k] = 0; m_st[k] = 0;
            end
        end else begin
            cyc++;
            nt = '0;
            nt[0] = (m_pre == CPU - 1);
            m_pre = (m_pre == CPU - 1) ? 0 : m_pre + 1;
            for (int l = 1; l < 4; l++) begin
                nt[l] = m_tick[l-1] && (m_dec[l] == 9);
                if (m_tick[l-1]) m_dec[l] = (m_dec[l] == 9) ? 0 : m_dec[l] + 1;
            end
            ssel = int'(m_ctrl[10:8]);
            if (ssel == 0) m_stamp++;
            else if (ssel <= 4 && m_tick[ssel-1]) m_stamp++;
            wctl = bus_sel && bus_wr && (bus_addr[4:2] == 3'd0);
            m_irq = '0;
            for (int ch = 0; ch < 4; ch++) begin
                en   = m_ctrl[16+ch];
                per  = m_ctrl[12+ch];
                rsel = int'((m_ctrl >> (2*ch)) & 32'd3);
                case (m_st[ch])
                    0: if (en) m_st[ch] = 1;
                    1: begin
                        if (!en) m_st[ch] = 0;
                        else if (m_tick[rsel]) begin
                            if (m_cnt[ch] == 0) begin
                                m_irq[ch] = 1'b1;
                                if (per) m_cnt[ch] = m_rel[ch];
                                else     m_st[ch] = 2;
                            end else m_cnt[ch]--;
                        end
                    end
                    default: if (wctl) begin m_st[ch] = 0; m_cnt[ch] = m_rel[ch]; end
                endcase
                if (bus_sel && bus_wr && int'(bus_addr[4:2]) == ch + 1) begin
                    m_cnt[ch] = int'(bus_wdata[15:0]);
                    m_rel[ch] = int'(bus_wdata[15:0]);
                end
            end
            if (wctl) m_ctrl = bus_wdata & 32'h000F_F7FF;
            m_tick = nt;
        end
    end

    function automatic bit [31:0] model_reg(input bit [4:0] a);
        int w = int'(a[4:2]);
        if (w == 0) return m_ctrl;
        if (w == 5) return m_stamp;
        if (w >= 1 && w <= 4) return 32'(m_cnt[w-1]);
        return 32'd0;
    endfunction

    task automatic check(input bit ok, input string req, input bit [31:0] act, input bit [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // per-clock comparison of interrupts, plus pulse bookkeeping
    int pulses [4];
    int last_at [4];
    int gap [4];
    always @(negedge clk) begin
        if (rst_n) begin
            check(irq == m_irq, "R8 irq vector (R6 R7 pulses)", 32'(irq), 32'(m_irq));
            for (int ch = 0; ch < 4; ch++) begin
                if (irq[ch]) begin
                    pulses[ch]++;
                    gap[ch] = cyc - last_at[ch];
                    last_at[ch] = cyc;
                end
            end
        end
    end

    task automatic wr(input bit [4:0] a, input bit [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input bit [4:0] a, output bit [31:0] v, input string req);
        bit [31:0] e;
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1;
        v = bus_rdata;
        e = model_reg(a);
        check(v == e, req, v, e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        bit [31:0] v;
        bit [31:0] v2;
        for (int k = 0; k < 4; k++) begin pulses[k] = 0; last_at[k] = 0; gap[k] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        rd(5'h00, v, "R1 control after reset"); check(v == 0, "R1 control zero", v, 0);
        rd(5'h04, v, "R1 count A after reset"); check(v == 0, "R1 count A zero", v, 0);
        rd(5'h10, v, "R1 count D after reset");
        rd(5'h14, v, "R1 stamp after reset");
        check(irq == 0, "R1 irq idle", 32'(irq), 0);

        // R2: reserved control bits read 0
        wr(5'h00, 32'hFFF0_F800);
        rd(5'h00, v, "R2 control readback"); check(v == 32'h0000_F000, "R2 control mask", v, 32'h0000_F000);

        // R9: stopped timestamp (code 5)
        wr(5'h00, 32'h0000_0500);
        rd(5'h14, v, "R9 stamp stopped");
        idle(30);
        rd(5'h14, v2, "R9 stamp stopped later"); check(v2 == v, "R9 stamp held", v2, v);

        // R10: writes to timestamp ignored
        wr(5'h14, 32'h1234_5678);
        rd(5'h14, v2, "R10 stamp write ignored"); check(v2 == v, "R10 stamp unchanged", v2, v);

        // R3 R9: stamp on 1 us tick advances 10 in 20 clocks
        wr(5'h00, 32'h0000_0100);
        rd(5'h14, v, "R3 stamp at 1us");
        idle(19);
        rd(5'h14, v2, "R3 stamp at 1us later"); check(v2 - v == 10, "R3 1us period", v2 - v, 10);

        // R9: system clock count
        wr(5'h00, 32'h0000_0000);
        rd(5'h14, v, "R9 stamp sysclk");
        idle(9);
        rd(5'h14, v2, "R9 stamp sysclk later"); check(v2 - v == 10, "R9 sysclk rate", v2 - v, 10);

        // R6 R11: channel A periodic N=3 on 1 us => gap 8 clocks
        wr(5'h04, 32'd3);
        rd(5'h04, v, "R11 count A load"); check(v == 3, "R11 count A value", v, 3);
        wr(5'h00, 32'h0001_1100);
        idle(60);
        check(gap[0] == 8, "R6 periodic interval A", 32'(gap[0]), 8);
        check(pulses[0] >= 6, "R6 periodic repeats A", 32'(pulses[0]), 6);
        wr(5'h04, 32'd40);
        rd(5'h04, v, "R11 count A reload while running");

        // R7: channel B one-shot N=5 on 10 us (code 1 at bits 3:2)
        wr(5'h08, 32'd5);
        wr(5'h00, 32'h0002_0104);
        idle(300);
        check(pulses[1] == 1, "R7 one-shot single pulse", 32'(pulses[1]), 1);
        rd(5'h08, v, "R7 one-shot holds zero"); check(v == 0, "R7 count zero", v, 0);
        wr(5'h00, 32'h0002_0104);
        rd(5'h08, v, "R7 control write reloads"); check(v == 5, "R7 reload value", v, 5);
        idle(300);
        check(pulses[1] == 2, "R7 restart pulse", 32'(pulses[1]), 2);

        // R5: channel C disable freezes count
        wr(5'h0C, 32'd100);
        wr(5'h00, 32'h0004_0100);
        idle(40);
        wr(5'h00, 32'h0000_0100);
        rd(5'h0C, v, "R5 frozen count");
        idle(50);
        rd(5'h0C, v2, "R5 frozen later"); check(v2 == v && v < 100, "R5 count frozen", v2, v);
        check(pulses[2] == 0, "R5 no irq when disabled", 32'(pulses[2]), 0);

        // R4: C on 100 us N=0 (gap 200), D on 1 ms N=1 (gap 4000)
        wr(5'h0C, 32'd0);
        wr(5'h10, 32'd1);
        wr(5'h00, 32'h000C_C0E0);
        idle(8600);
        check(gap[2] == 200, "R4 100us code", 32'(gap[2]), 200);
        check(gap[3] == 4000, "R4 1ms code", 32'(gap[3]), 4000);
        rd(5'h00, v, "R2 control readback final");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule